// File: doc/BRIEF.md
# Cartridge Bank Controller

This block watches CPU writes aimed at the cartridge ROM half of the address map and turns them into bank-select state for the cartridge side of a memory system. The top three address bits sort each write into one of four control windows: RAM gate, ROM bank, RAM bank or clock-register window, and clock snapshot. The data byte is then interpreted according to a two-bit personality input. The outputs are a ROM bank number, an external RAM bank number, a RAM enable, a clock-window flag, the selected clock register index, and a one-cycle snapshot pulse. The ROM and RAM arrays and the clock counter are outside the block.

Three personalities share one decoder. The compact personality takes a 5-bit bank field and keeps the two upper bank bits. The clock personality takes a 7-bit bank field and uses the third window both for RAM banks and for clock registers. The wide-RAM personality takes a 7-bit bank field, allows bank zero, and offers sixteen RAM banks. Bank zero is replaced by bank one where the personality requires it. The requested bank is then wrapped into the configured ROM size.

The snapshot control is a two-state machine. In `LATCH_OPEN`, a write of 1 fires the pulse and takes the *arm* transition to `LATCH_HELD`. In `LATCH_HELD`, a write of 0 takes the *release* transition back to `LATCH_OPEN`. Every other write leaves the state as it is.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, the clock window is off with index 0, and the snapshot machine is in `LATCH_OPEN`. The first qualifying snapshot write therefore fires a pulse.
- R2: A write with `cpu_addr_hi`=0, in any personality, acts on the RAM gate. Data 0x0A sets `ram_en`, data 0x00 clears it, and any other value leaves it unchanged.
- R3: With `mode`=0 (compact), a write with `cpu_addr_hi`=1 loads the bank with data[4:0]. A zero field becomes 1, and bits [6:5] of the current bank are kept.
- R4: With `mode`=1 (clock), a write with `cpu_addr_hi`=1 loads the bank with data[6:0]. A zero value becomes 1.
- R5: With `mode`=2 or 3 (wide RAM), a write with `cpu_addr_hi`=1 loads the bank with data[6:0], and zero is kept as zero.
- R6: After any zero substitution, the ROM bank is reduced modulo 2^`ROM_BANKS_LOG2` (64 banks by default), so no substitution is applied again. For example, 0x40 in clock mode gives bank 0, and 0x7F gives 0x3F.
- R7: In clock mode, a write with `cpu_addr_hi`=2 and data below 4 sets the RAM bank to that value and clears `rtc_sel`. Data 8 to 0x0C sets `rtc_idx` to data-8 and sets `rtc_sel`, leaving the RAM bank unchanged. Any other data value has no effect.
- R8: In wide-RAM mode, a write with `cpu_addr_hi`=2 and data below 0x10 sets the RAM bank, and larger values are ignored. `rtc_sel` is not changed.
- R9: In clock mode, a write with `cpu_addr_hi`=3 drives the snapshot machine. A value of 1 in `LATCH_OPEN` raises `latch_pulse` for exactly one cycle, in the cycle after the write, and arms the machine. A value of 0 in `LATCH_HELD` releases it. A 1 while held, and any other value, fires nothing.
- R10: Several writes change nothing: writes with `cpu_addr_hi`≥4, cycles with `wr_en` low, windows 2 and 3 in compact mode, and window 3 in wide-RAM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_hi | input | 3 | CPU address bits 15:13 |
| wr_data | input | 8 | CPU write data |
| mode | input | 2 | Personality: 0 compact, 1 clock, 2/3 wide RAM |
| rom_bank | output | ROM_BANK_W | Switchable ROM bank number |
| ram_bank | output | 4 | External RAM bank number |
| ram_en | output | 1 | External RAM access enabled |
| rtc_sel | output | 1 | RAM window maps clock registers |
| rtc_idx | output | 3 | Selected clock register, 0 to 4 |
| latch_pulse | output | 1 | One-cycle clock snapshot request |

## Verification
Zero substitution and size wrapping both act within a single bank-register update, and their order decides the result. The bench writes 0x00 and 0x40 in clock mode and 0x00 in compact mode, using a bank whose upper bits are set. It expects 1, 0 and a kept-upper-bits value respectively, which shows that wrapping follows substitution and does not trigger a second substitution. The clock-window entry and the snapshot pulse are also provoked in consecutive cycles, to confirm that each leaves the other untouched.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int RAM_BANK_W = 4;
    localparam int RTC_IDX_W  = 3;

    typedef enum logic [1:0] {
        MODE_ROM5      = 2'd0,
        MODE_RTC       = 2'd1,
        MODE_RAM16     = 2'd2,
        MODE_RAM16_ALT = 2'd3
    } cbc_mode_e;

    typedef struct packed {
        logic gate_wr;
        logic rom_wr;
        logic win_wr;
        logic snap_wr;
    } cbc_strobe_t;

    typedef enum logic {
        LATCH_OPEN = 1'b0,
        LATCH_HELD = 1'b1
    } cbc_latch_e;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
(
    input  logic        wr_en,
    input  logic [2:0]  cpu_addr_hi,
    input  cbc_mode_e   mode,
    output cbc_strobe_t strobe
);
    logic win_ok;
    logic snap_ok;

    always_comb begin
        unique case (mode)
            MODE_ROM5:      begin win_ok = 1'b0; snap_ok = 1'b0; end
            MODE_RTC:       begin win_ok = 1'b1; snap_ok = 1'b1; end
            MODE_RAM16,
            MODE_RAM16_ALT: begin win_ok = 1'b1; snap_ok = 1'b0; end
        endcase
    end

    always_comb begin
        strobe = '0;
        if (wr_en) begin
            unique case (cpu_addr_hi)
                3'd0:    strobe.gate_wr = 1'b1;
                3'd1:    strobe.rom_wr  = 1'b1;
                3'd2:    strobe.win_wr  = win_ok;
                3'd3:    strobe.snap_wr = snap_ok;
                default: strobe = '0;
            endcase
        end
    end
endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
    import cbc_pkg::*;
#(
    parameter int ROM_BANK_W     = 7,
    parameter int ROM_BANKS_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cbc_strobe_t           strobe,
    input  cbc_mode_e             mode,
    input  logic [7:0]            wr_data,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en,
    output logic                  rtc_sel,
    output logic [RTC_IDX_W-1:0]  rtc_idx
);
    localparam int                  ROM_COUNT = 1 << ROM_BANKS_LOG2;
    localparam logic [ROM_BANK_W-1:0] ROM_MASK  = ROM_BANK_W'(ROM_COUNT - 1);
    localparam logic [ROM_BANK_W-1:0] LOW5_MASK = ROM_BANK_W'(31);

    logic [ROM_BANK_W-1:0] rom_req;
    logic [4:0]            low5;
    logic [6:0]            wide7;

    always_comb begin
        low5  = (wr_data[4:0] == 5'd0) ? 5'd1 : wr_data[4:0];
        wide7 = wr_data[6:0];
        unique case (mode)
            MODE_ROM5:      rom_req = (rom_bank & ~LOW5_MASK) | ROM_BANK_W'(low5);
            MODE_RTC:       rom_req = ROM_BANK_W'((wide7 == 7'd0) ? 7'd1 : wide7);
            MODE_RAM16,
            MODE_RAM16_ALT: rom_req = ROM_BANK_W'(wide7);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
            ram_en   <= 1'b0;
            rtc_sel  <= 1'b0;
            rtc_idx  <= '0;
        end else begin
            if (strobe.gate_wr) begin
                if (wr_data == 8'h0A)      ram_en <= 1'b1;
                else if (wr_data == 8'h00) ram_en <= 1'b0;
            end
            if (strobe.rom_wr)
                rom_bank <= rom_req & ROM_MASK;
            if (strobe.win_wr) begin
                if (mode == MODE_RTC) begin
                    if (wr_data < 8'd4) begin
                        ram_bank <= RAM_BANK_W'(wr_data[1:0]);
                        rtc_sel  <= 1'b0;
                    end else if (wr_data >= 8'd8 && wr_data <= 8'h0C) begin
                        rtc_idx  <= RTC_IDX_W'(wr_data[2:0]);
                        rtc_sel  <= 1'b1;
                    end
                end else if (wr_data < 8'h10) begin
                    ram_bank <= RAM_BANK_W'(wr_data[3:0]);
                end
            end
        end
    end
endmodule

// File: rtl/cbc_latch_fsm.sv
module cbc_latch_fsm
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snap_wr,
    input  logic [7:0] wr_data,
    output logic       latch_pulse
);
    cbc_latch_e state_q;
    cbc_latch_e state_d;
    logic       fire;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            LATCH_OPEN: if (snap_wr && wr_data == 8'h01) begin
                state_d = LATCH_HELD;
                fire    = 1'b1;
            end
            LATCH_HELD: if (snap_wr && wr_data == 8'h00)
                state_d = LATCH_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LATCH_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_pulse <= 1'b0;
        else        latch_pulse <= fire;
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_BANK_W     = 7,
    parameter int ROM_BANKS_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            cpu_addr_hi,
    input  logic [7:0]            wr_data,
    input  logic [1:0]            mode,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [3:0]            ram_bank,
    output logic                  ram_en,
    output logic                  rtc_sel,
    output logic [2:0]            rtc_idx,
    output logic                  latch_pulse
);
    cbc_mode_e   mode_e;
    cbc_strobe_t strobe;

    assign mode_e = cbc_mode_e'(mode);

    cbc_decode u_decode (
        .wr_en       (wr_en),
        .cpu_addr_hi (cpu_addr_hi),
        .mode        (mode_e),
        .strobe      (strobe)
    );

    cbc_bank_regs #(
        .ROM_BANK_W     (ROM_BANK_W),
        .ROM_BANKS_LOG2 (ROM_BANKS_LOG2)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .mode     (mode_e),
        .wr_data  (wr_data),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_en   (ram_en),
        .rtc_sel  (rtc_sel),
        .rtc_idx  (rtc_idx)
    );

    cbc_latch_fsm u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap_wr     (strobe.snap_wr),
        .wr_data     (wr_data),
        .latch_pulse (latch_pulse)
    );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
    parameter int ROM_BANK_W = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [2:0]            cpu_addr_hi,
    input logic [7:0]            wr_data,
    input logic [1:0]            mode,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [3:0]            ram_bank,
    input logic                  ram_en,
    input logic                  rtc_sel,
    input logic [2:0]            rtc_idx,
    input logic                  latch_pulse
);
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_r1: assert (rom_bank == ROM_BANK_W'(1) && ram_bank == 4'd0 &&
                                !ram_en && !rtc_sel && rtc_idx == 3'd0 && !latch_pulse);
        end
    end

    p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cpu_addr_hi == 3'd0) |=> $stable(ram_en));

    p_gate_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr_hi == 3'd0 && wr_data == 8'h0A) |=> ram_en);

    p_rom5_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr_hi == 3'd1 && mode == 2'd0) |=> (rom_bank[4:0] != 5'd0));

    p_rtc_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtc_sel) |-> $past(wr_en && cpu_addr_hi == 3'd2 && mode == 2'd1 &&
                                 wr_data >= 8'd8 && wr_data <= 8'h0C));

    p_wide_keeps_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr_hi == 3'd2 && mode[1]) |=> $stable(rtc_sel));

    p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |-> $past(wr_en && cpu_addr_hi == 3'd3 && mode == 2'd1 && wr_data == 8'h01));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> !latch_pulse);

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || cpu_addr_hi[2]) |=> ($stable(rom_bank) && $stable(ram_bank) &&
            $stable(ram_en) && $stable(rtc_sel) && $stable(rtc_idx)));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_BANK_W(ROM_BANK_W)) u_chk (.*);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] cpu_addr_hi = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] mode = 2'd0;
    logic [6:0] rom_bank;
    logic [3:0] ram_bank;
    logic       ram_en, rtc_sel, latch_pulse;
    logic [2:0] rtc_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cart_bank_ctrl i_cart_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cpu_addr_hi(cpu_addr_hi),
        .wr_data(wr_data), .mode(mode), .rom_bank(rom_bank), .ram_bank(ram_bank),
        .ram_en(ram_en), .rtc_sel(rtc_sel), .rtc_idx(rtc_idx), .latch_pulse(latch_pulse)
    );

    typedef struct {
        logic [6:0] rom;
        logic [3:0] ram;
        logic       en;
        logic       sel;
        logic [2:0] idx;
        logic       pulse;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [6:0] m_rom = 7'd1;
    logic [3:0] m_ram = 4'd0;
    logic       m_en = 0, m_sel = 0, m_held = 0;
    logic [2:0] m_idx = 3'd0;

    task automatic push(input logic pulse, input string tag);
        exp_t e;
        e.rom = m_rom; e.ram = m_ram; e.en = m_en; e.sel = m_sel;
        e.idx = m_idx; e.pulse = pulse; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [1:0] md, input logic [2:0] hi, input logic [7:0] d,
                      input string tag);
        logic       p = 1'b0;
        logic [4:0] lo;
        logic [6:0] r;
        @(negedge clk);
        mode = md; cpu_addr_hi = hi; wr_data = d; wr_en = 1'b1;
        case (hi)
            3'd0: if (d == 8'h0A) m_en = 1; else if (d == 8'h00) m_en = 0;
            3'd1: begin
                if (md == 2'd0) begin
                    lo = (d[4:0] == 0) ? 5'd1 : d[4:0];
                    r  = (m_rom & 7'h60) | {2'b00, lo};
                end else if (md == 2'd1) r = (d[6:0] == 0) ? 7'd1 : d[6:0];
                else r = d[6:0];
                m_rom = r & 7'h3F;
            end
            3'd2: begin
                if (md == 2'd1) begin
                    if (d < 4) begin m_ram = d[3:0]; m_sel = 0; end
                    else if (d >= 8 && d <= 12) begin m_idx = 3'(d - 8); m_sel = 1; end
                end else if (md >= 2'd2 && d < 16) m_ram = d[3:0];
            end
            3'd3: if (md == 2'd1) begin
                if (m_held && d == 0) m_held = 0;
                else if (!m_held && d == 1) begin m_held = 1; p = 1; end
            end
            default: ;
        endcase
        push(p, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            push(1'b0, tag);
        end
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rom_bank !== e.rom || ram_bank !== e.ram || ram_en !== e.en ||
                    rtc_sel !== e.sel || rtc_idx !== e.idx || latch_pulse !== e.pulse) begin
                    fails++;
                    $display("FAIL %s: actual rom=%h ram=%h en=%b sel=%b idx=%0d pulse=%b expected rom=%h ram=%h en=%b sel=%b idx=%0d pulse=%b",
                             e.tag, rom_bank, ram_bank, ram_en, rtc_sel, rtc_idx, latch_pulse,
                             e.rom, e.ram, e.en, e.sel, e.idx, e.pulse);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rom_bank !== 7'd1 || ram_bank !== 4'd0 || ram_en !== 1'b0 ||
            rtc_sel !== 1'b0 || rtc_idx !== 3'd0 || latch_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual rom=%h ram=%h en=%b sel=%b idx=%0d pulse=%b expected 01 0 0 0 0 0",
                     rom_bank, ram_bank, ram_en, rtc_sel, rtc_idx, latch_pulse);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1 idle after reset");

        // R10: upper address windows and idle strobe
        wr(2'd1, 3'd4, 8'h0A, "R10 hi=4 gate value");
        wr(2'd1, 3'd5, 8'h05, "R10 hi=5 bank value");
        wr(2'd1, 3'd7, 8'h01, "R10 hi=7 snapshot value");
        // R2 RAM gate
        wr(2'd0, 3'd0, 8'h0A, "R2 enable");
        wr(2'd0, 3'd0, 8'h05, "R2 other keeps");
        wr(2'd0, 3'd0, 8'h00, "R2 disable");
        wr(2'd0, 3'd0, 8'hFF, "R2 other keeps off");
        wr(2'd1, 3'd0, 8'h0A, "R2 enable clock mode");
        // R4 / R6
        wr(2'd1, 3'd1, 8'h25, "R4 load");
        wr(2'd1, 3'd1, 8'h00, "R4 zero to one");
        wr(2'd1, 3'd1, 8'h7F, "R6 wrap 7F");
        wr(2'd1, 3'd1, 8'h40, "R6 wrap after substitution");
        // R3
        wr(2'd1, 3'd1, 8'h25, "R4 preset upper bits");
        wr(2'd0, 3'd1, 8'h03, "R3 keep upper bits");
        wr(2'd0, 3'd1, 8'h00, "R3 zero field to one");
        wr(2'd0, 3'd1, 8'hE4, "R3 ignore data high bits");
        // R5
        wr(2'd2, 3'd1, 8'h00, "R5 zero kept");
        wr(2'd2, 3'd1, 8'h15, "R5 load");
        wr(2'd3, 3'd1, 8'h00, "R5 mode3 zero kept");
        // R7
        wr(2'd1, 3'd2, 8'h02, "R7 ram bank");
        wr(2'd1, 3'd2, 8'h09, "R7 enter window");
        wr(2'd1, 3'd2, 8'h05, "R7 gap ignored");
        wr(2'd1, 3'd2, 8'h0D, "R7 above window ignored");
        wr(2'd1, 3'd2, 8'h0C, "R7 last register");
        wr(2'd1, 3'd3, 8'h01, "R9 pulse next to window write");
        wr(2'd1, 3'd2, 8'h03, "R7 leave window");
        wr(2'd1, 3'd2, 8'h08, "R7 first register");
        // R8
        wr(2'd2, 3'd2, 8'h05, "R8 ram bank keeps sel");
        wr(2'd2, 3'd2, 8'h0F, "R8 top bank");
        wr(2'd2, 3'd2, 8'h10, "R8 above ignored");
        wr(2'd3, 3'd2, 8'h07, "R8 mode3");
        // R10 mode gating
        wr(2'd0, 3'd2, 8'h01, "R10 compact window ignored");
        wr(2'd1, 3'd3, 8'h00, "R9 release");
        wr(2'd0, 3'd3, 8'h01, "R10 compact snapshot ignored");
        wr(2'd2, 3'd3, 8'h01, "R10 wide snapshot ignored");
        idle(2, "R10 idle");
        // R9 sequencing
        wr(2'd1, 3'd3, 8'h01, "R9 fire");
        wr(2'd1, 3'd3, 8'h01, "R9 held no refire");
        wr(2'd1, 3'd3, 8'h02, "R9 other value");
        wr(2'd1, 3'd3, 8'h00, "R9 release");
        wr(2'd1, 3'd3, 8'h00, "R9 release again");
        wr(2'd1, 3'd3, 8'h01, "R9 refire");
        idle(3, "R9 idle");

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule